// File: doc/BRIEF.md
# Adaptive Half-Bridge Dead-Time Controller

This block is the digital control core of a half-bridge gate driver. It takes one non-inverting PWM command and produces a high-side gate enable and a low-side gate enable. The two enables are never high together. The block does not use a fixed dead time. Before it turns a switch on, it waits for a comparator flag that shows the opposite switch has really turned off. The high side waits for the low-side gate voltage to fall below threshold. The low side waits for the switch node to fall below threshold. If the switch node never falls, a timeout forces the low side on. It stays on until the next PWM edge.

Several overrides sit above the PWM path. Listed from strongest to weakest, they are:
- a kill condition, which turns both switches off. It is raised by shutdown, supply undervoltage, thermal trip, or the power-on delay still running.
- brake, which turns the low side on and the high side off.
- bootstrap undervoltage, which keeps only the high side off.

Every asynchronous flag passes through a two-flop synchronizer. The die temperature is a registered unsigned value in degrees Celsius, and it is compared with hysteresis. A 7-bit status word reports the following: the FSM state (bits 6:4), the timeout-forced condition (bit 3), thermal trip (bit 2), supply undervoltage (bit 1) and bootstrap undervoltage (bit 0).

The state machine has seven states:
- OFF = 0
- BRAKE = 1
- LS_WAIT = 2
- LS_ON = 3
- LS_FORCED = 4
- HS_WAIT = 5
- HS_ON = 6

Its transitions are:
- Any state goes to OFF on kill, and to BRAKE on brake when there is no kill.
- OFF and BRAKE go to HS_WAIT when PWM is high, and to LS_ON when PWM is low.
- HS_WAIT goes to HS_ON once the low-gate flag is set and the bootstrap supply is good. It goes to LS_ON if PWM falls first.
- HS_ON goes to LS_WAIT when PWM falls. It goes back to HS_WAIT on bootstrap undervoltage.
- LS_WAIT goes to LS_ON when the switch-node flag is set. It goes to LS_FORCED when the timeout expires, and to HS_WAIT when PWM rises.
- LS_ON and LS_FORCED go to HS_WAIT when PWM rises.

The high-side enable is high only in HS_ON. The low-side enable is high in LS_ON, LS_FORCED and BRAKE. Both enables are registered.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While reset is held, both enables are low and the status word is all zero (state OFF).
- R2: After PWM rises, the low-side enable drops and the high-side enable stays low until the synchronized low-gate-below-threshold flag is 1; then the high-side enable rises (state HS_WAIT = 5, then HS_ON = 6).
- R3: After PWM falls, the high-side enable drops and the low-side enable stays low until the synchronized switch-node-below-threshold flag is 1; then the low-side enable rises (state LS_WAIT = 2, then LS_ON = 3).
- R4: If the switch-node flag stays 0, the low-side enable rises exactly TO_CYC clock cycles after the high-side enable fell, where TO_CYC = TIMEOUT_NS*CLK_MHZ/1000. State LS_FORCED = 4 is then shown and status bit 3 is set. This holds until the next PWM rise, even if the switch-node flag later becomes 1.
- R5: With brake high and no kill condition, the low-side enable is high and the high-side enable is low whatever the PWM level (state BRAKE = 1).
- R6: With the active-low shutdown input low, both enables are low, whatever the brake and PWM inputs.
- R7: With supply undervoltage active, both enables are low and status bit 1 is set.
- R8: With bootstrap undervoltage active, the high-side enable is low and the low-side enable follows its normal behaviour. Status bit 0 is set, and a PWM-high request waits in HS_WAIT.
- R9: The thermal trip sets when the temperature is above HOT_ON_C (165) and clears only when it is below HOT_OFF_C (140). While it is set, both enables are low and status bit 2 is set. A value of exactly 165 does not trip, and a value of exactly 140 does not clear.
- R10: After supply undervoltage clears, no enable rises until POR_CYC = POR_NS*CLK_MHZ/1000 cycles have passed.
- R11: When shutdown, a fault or brake is removed while PWM is high, the block passes through HS_WAIT and needs the low-gate flag before the high-side enable rises.
- R12: The high-side and low-side enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Non-inverting PWM command (asynchronous) |
| brake_i | input | 1 | Brake request, active high |
| sd_n_i | input | 1 | Shutdown, active low |
| uv_supply_i | input | 1 | Supply undervoltage flag |
| uv_boot_i | input | 1 | Bootstrap undervoltage flag |
| sw_low_i | input | 1 | Switch node below threshold |
| lg_low_i | input | 1 | Low-side gate below threshold |
| temp_i | input | TEMP_W | Die temperature, unsigned °C |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| status_o | output | 7 | {state[2:0], forced, thermal, uv_supply, uv_boot} |

## Verification
The checker watches these properties on every cycle:
- The two enables are never both high.
- Every high-side rise comes from HS_WAIT.
- A forced state always has the low side on.
- A reported undervoltage or thermal flag is followed by the matching enables being off.
- LS_WAIT never lasts longer than the timeout.

Only the bench scenarios can show the following:
- The exact timeout length and the power-on delay.
- The thermal hysteresis boundaries at 165 and 140.
- That the forced state persists after the switch node finally falls.
- The override priority, by sweeping all 64 combinations of PWM, brake, shutdown, both undervoltage flags and thermal state.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_BRAKE     = 3'd1,
        ST_LS_WAIT   = 3'd2,
        ST_LS_ON     = 3'd3,
        ST_LS_FORCED = 3'd4,
        ST_HS_WAIT   = 3'd5,
        ST_HS_ON     = 3'd6
    } hb_state_e;

    typedef struct packed {
        hb_state_e state;
        logic      forced;
        logic      hot;
        logic      uv_supply;
        logic      uv_boot;
    } hb_status_t;

    localparam int STATUS_W = $bits(hb_status_t);

    // Bit positions inside the synchronizer vector
    localparam int SY_PWM   = 6;
    localparam int SY_BRAKE = 5;
    localparam int SY_SDN   = 4;
    localparam int SY_UVS   = 3;
    localparam int SY_UVB   = 2;
    localparam int SY_SWL   = 1;
    localparam int SY_LGL   = 0;
    localparam int SY_W     = 7;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/hb_por.sv
module hb_por #(
    parameter int CYC = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    output logic ready_o
);

    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!supply_ok_i) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign ready_o = (cnt_q == LAST);

endmodule

// File: rtl/hb_thermal.sv
module hb_thermal #(
    parameter int TW  = 8,
    parameter int HI  = 165,
    parameter int LO  = 140
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_i,
    output logic          hot_o
);

    localparam logic [TW-1:0] HI_V = TW'(HI);
    localparam logic [TW-1:0] LO_V = TW'(LO);

    logic [TW-1:0] temp_q;
    logic          hot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
            hot_q  <= 1'b0;
        end else begin
            temp_q <= temp_i;
            if (temp_q > HI_V)      hot_q <= 1'b1;
            else if (temp_q < LO_V) hot_q <= 1'b0;
        end
    end

    assign hot_o = hot_q;

endmodule

// File: rtl/hb_timer.sv
module hb_timer #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run_i)     cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwm_i,
    input  logic      brake_i,
    input  logic      kill_i,
    input  logic      uv_boot_i,
    input  logic      sw_low_i,
    input  logic      lg_low_i,
    input  logic      expired_i,
    output hb_state_e state_o,
    output logic      timer_run_o,
    output logic      hs_en_o,
    output logic      ls_en_o
);

    hb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (kill_i) begin
            state_d = ST_OFF;
        end else if (brake_i) begin
            state_d = ST_BRAKE;
        end else begin
            unique case (state_q)
                ST_OFF, ST_BRAKE: begin
                    state_d = pwm_i ? ST_HS_WAIT : ST_LS_ON;
                end
                ST_HS_WAIT: begin
                    if (!pwm_i)                      state_d = ST_LS_ON;
                    else if (lg_low_i && !uv_boot_i) state_d = ST_HS_ON;
                end
                ST_HS_ON: begin
                    if (!pwm_i)         state_d = ST_LS_WAIT;
                    else if (uv_boot_i) state_d = ST_HS_WAIT;
                end
                ST_LS_WAIT: begin
                    if (pwm_i)          state_d = ST_HS_WAIT;
                    else if (sw_low_i)  state_d = ST_LS_ON;
                    else if (expired_i) state_d = ST_LS_FORCED;
                end
                ST_LS_ON, ST_LS_FORCED: begin
                    if (pwm_i) state_d = ST_HS_WAIT;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Registered gate enables, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_en_o <= 1'b0;
            ls_en_o <= 1'b0;
        end else begin
            hs_en_o <= (state_d == ST_HS_ON);
            ls_en_o <= (state_d == ST_LS_ON) || (state_d == ST_LS_FORCED) ||
                       (state_d == ST_BRAKE);
        end
    end

    assign state_o     = state_q;
    assign timer_run_o = (state_q == ST_LS_WAIT);

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
    import hb_pkg::*;
#(
    parameter int CLK_MHZ    = 250,
    parameter int TIMEOUT_NS = 400,
    parameter int POR_NS     = 2500000,
    parameter int TEMP_W     = 8,
    parameter int HOT_ON_C   = 165,
    parameter int HOT_OFF_C  = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_i,
    input  logic              brake_i,
    input  logic              sd_n_i,
    input  logic              uv_supply_i,
    input  logic              uv_boot_i,
    input  logic              sw_low_i,
    input  logic              lg_low_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              hs_en_o,
    output logic              ls_en_o,
    output logic [6:0]        status_o
);

    localparam int TO_CYC  = TIMEOUT_NS * CLK_MHZ / 1000;
    localparam int POR_CYC = POR_NS * CLK_MHZ / 1000;

    logic [SY_W-1:0] raw, syn;
    logic            hot, por_ok, expired, timer_run, kill;
    hb_state_e       state;
    hb_status_t      stat;

    assign raw[SY_PWM]   = pwm_i;
    assign raw[SY_BRAKE] = brake_i;
    assign raw[SY_SDN]   = sd_n_i;
    assign raw[SY_UVS]   = uv_supply_i;
    assign raw[SY_UVB]   = uv_boot_i;
    assign raw[SY_SWL]   = sw_low_i;
    assign raw[SY_LGL]   = lg_low_i;

    hb_sync #(.W(SY_W), .STAGES(2)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw),
        .q_o  (syn)
    );

    hb_por #(.CYC(POR_CYC)) por_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok_i(!syn[SY_UVS]),
        .ready_o    (por_ok)
    );

    hb_thermal #(.TW(TEMP_W), .HI(HOT_ON_C), .LO(HOT_OFF_C)) therm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .temp_i(temp_i),
        .hot_o (hot)
    );

    hb_timer #(.CYC(TO_CYC)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (timer_run),
        .expired_o(expired)
    );

    assign kill = !syn[SY_SDN] || syn[SY_UVS] || hot || !por_ok;

    hb_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_i      (syn[SY_PWM]),
        .brake_i    (syn[SY_BRAKE]),
        .kill_i     (kill),
        .uv_boot_i  (syn[SY_UVB]),
        .sw_low_i   (syn[SY_SWL]),
        .lg_low_i   (syn[SY_LGL]),
        .expired_i  (expired),
        .state_o    (state),
        .timer_run_o(timer_run),
        .hs_en_o    (hs_en_o),
        .ls_en_o    (ls_en_o)
    );

    always_comb begin
        stat.state     = state;
        stat.forced    = (state == ST_LS_FORCED);
        stat.hot       = hot;
        stat.uv_supply = syn[SY_UVS];
        stat.uv_boot   = syn[SY_UVB];
    end

    assign status_o = stat;

endmodule

// File: rtl/hb_deadtime_chk.sv
module hb_deadtime_chk
    import hb_pkg::*;
#(
    parameter int TO_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_en_o,
    input logic       ls_en_o,
    input logic [6:0] status_o
);

    logic [2:0] st;
    int         wait_cnt;

    assign st = status_o[6:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wait_cnt <= 0;
        else if (st == 3'(ST_LS_WAIT)) wait_cnt <= wait_cnt + 1;
        else                         wait_cnt <= 0;
    end

    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o));

    // R2
    hs_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en_o) |-> $past(st) == 3'(ST_HS_WAIT));

    // R4
    forced_ls_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3] |-> ls_en_o && !hs_en_o);

    // R4
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'(ST_LS_WAIT)) |-> (wait_cnt < TO_CYC));

    // R7
    uv_supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1] |=> !hs_en_o && !ls_en_o);

    // R8
    uv_boot_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |=> !hs_en_o);

    // R9
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2] |=> !hs_en_o && !ls_en_o);

endmodule

bind hb_deadtime_ctrl hb_deadtime_chk #(.TO_CYC(TO_CYC)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_en_o (hs_en_o),
    .ls_en_o (ls_en_o),
    .status_o(status_o)
);

// File: tb/hb_deadtime_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_tb_top;

    localparam int TO_EXP = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm = 1'b0, brake = 1'b0, sd_n = 1'b1;
    logic       uvs = 1'b1, uvb = 1'b0, swl = 1'b1, lgl = 1'b1;
    logic [7:0] temp = 8'd25;
    logic       hs, ls;
    logic [6:0] status;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    hb_deadtime_ctrl #(
        .CLK_MHZ(250), .TIMEOUT_NS(400), .POR_NS(200),
        .TEMP_W(8), .HOT_ON_C(165), .HOT_OFF_C(140)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .brake_i(brake), .sd_n_i(sd_n),
        .uv_supply_i(uvs), .uv_boot_i(uvb), .sw_low_i(swl), .lg_low_i(lgl),
        .temp_i(temp), .hs_en_o(hs), .ls_en_o(ls), .status_o(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 hs", int'(hs), 0);
        chk("R1 ls", int'(ls), 0);
        chk("R1 status", int'(status), 0);
        rst_n = 1'b1;
        cyc(10);
        chk("R7 uv both off", int'({hs, ls}), 0);
        chk("R7 status bit1", int'(status[1]), 1);

        // R10 power-on delay after supply becomes valid
        uvs = 1'b0;
        cyc(50);
        chk("R10 early ls", int'(ls), 0);
        cyc(6);
        chk("R10 late ls", int'(ls), 1);
        chk("R3 state LS_ON", int'(status[6:4]), 3);

        // R2 handshake toward high side
        lgl = 1'b0;
        pwm = 1'b1;
        cyc(20);
        chk("R2 hs waits", int'(hs), 0);
        chk("R2 ls dropped", int'(ls), 0);
        chk("R2 state HS_WAIT", int'(status[6:4]), 5);
        lgl = 1'b1;
        cyc(5);
        chk("R2 hs on", int'(hs), 1);

        // R3 handshake toward low side
        swl = 1'b0;
        pwm = 1'b0;
        cyc(20);
        chk("R3 hs off", int'(hs), 0);
        chk("R3 ls waits", int'(ls), 0);
        chk("R3 state LS_WAIT", int'(status[6:4]), 2);
        swl = 1'b1;
        cyc(5);
        chk("R3 ls on", int'(ls), 1);
        chk("R3 not forced", int'(status[3]), 0);

        // Sweep of overrides: pwm, brake, sd_n, uv supply, uv boot, thermal
        for (int v = 0; v < 64; v++) begin
            logic p, b, s, us, ub, ht;
            int   st;
            {p, b, s, us, ub, ht} = 6'(v);
            pwm = p; brake = b; sd_n = s; uvs = us; uvb = ub;
            temp = ht ? 8'd170 : 8'd25;
            cyc(60);
            if (!s || us || ht)  st = 0;
            else if (b)          st = 1;
            else if (p)          st = ub ? 5 : 6;
            else                 st = 3;
            chk("R5 R6 R7 R8 R9 sweep hs", int'(hs), int'(st == 6));
            chk("R5 R6 R7 R8 R9 sweep ls", int'(ls), int'(st == 1 || st == 3));
            chk("R5 R6 R7 R8 R9 sweep status", int'(status),
                int'({3'(st), 1'b0, ht, us, ub}));
        end
        pwm = 1'b1; brake = 1'b0; sd_n = 1'b1; uvs = 1'b0; uvb = 1'b0; temp = 8'd25;
        cyc(70);
        chk("R2 back to hs", int'(hs), 1);

        // R4 timeout forcing
        swl = 1'b0;
        pwm = 1'b0;
        for (int i = 0; i < 20 && hs; i++) @(negedge clk);
        begin
            int n = 0;
            while (!ls && n < 300) begin
                @(negedge clk);
                n++;
            end
            chk("R4 timeout cycles", n, TO_EXP);
        end
        chk("R4 forced bit", int'(status[3]), 1);
        swl = 1'b1;
        cyc(10);
        chk("R4 forced held", int'(status[6:4]), 4);
        pwm = 1'b1;
        cyc(10);
        chk("R4 exit on pwm", int'(hs), 1);

        // R11 recovery from shutdown goes through handshake
        sd_n = 1'b0;
        cyc(10);
        chk("R6 both off", int'({hs, ls}), 0);
        lgl = 1'b0;
        sd_n = 1'b1;
        cyc(10);
        chk("R11 hs waits", int'(hs), 0);
        chk("R11 state HS_WAIT", int'(status[6:4]), 5);
        lgl = 1'b1;
        cyc(5);
        chk("R11 hs on", int'(hs), 1);

        // R9 thermal hysteresis boundaries
        temp = 8'd165;
        cyc(10);
        chk("R9 165 no trip", int'(hs), 1);
        temp = 8'd166;
        cyc(10);
        chk("R9 166 trips", int'({hs, ls, status[2]}), 1);
        temp = 8'd140;
        cyc(10);
        chk("R9 140 holds", int'(status[2]), 1);
        temp = 8'd139;
        cyc(10);
        chk("R9 139 clears", int'({hs, status[2]}), 2);

        // R8 boot undervoltage leaves low side alone
        uvb = 1'b1;
        pwm = 1'b0;
        cyc(10);
        chk("R8 ls normal", int'({hs, ls}), 1);

        finish_run();
    end

endmodule